// File: doc/BRIEF.md
# Sum-of-Products Macrocell with Product-Term Expanders

This block is one configurable logic cell that produces a single output as an OR of AND terms. It holds five local product terms. Each term can look at every signal of its AND plane, which is a general-purpose routing bus together with a pool of shared expander terms. For each of those signals, each term chooses whether to use it true, use it inverted, or ignore it. Static configuration vectors, held steady by the surrounding fabric, select everything.

When a cell needs more than five terms, its neighbours can lend it theirs over a one-bit parallel-expander chain. Three lending neighbours give up to fifteen extra terms. A cell lends a term by routing it onto the chain instead of into its own sum. The chain input from the previous cell is always passed on down the chain, and it is added to the local sum only when this cell is set to consume it.

One local term can also be exported, inverted, to the shared pool. By De Morgan it then acts as an OR of complemented literals for every cell that reads the pool. A cell group of sixteen gives a pool of sixteen such terms.

The sum either goes straight to the output or through a D register. That register has a clock enable, an asynchronous active-low clear, an asynchronous active-low preset and a synchronous reset.

Top module: `sop_macrocell`

## Requirements
- R1: The AND plane has N_IN+N_SHR inputs. Index i < N_IN is `bus_in[i]` and index N_IN+j is `shr_in[j]`. Term t reads its code for input i from `cfg_mask[t*2*(N_IN+N_SHR) + 2*i +: 2]`. Code 00 ignores the input, 01 requires it to be 1, 10 requires it to be 0, and 11 forces the term to 0.
- R2: A term whose bit in `cfg_pt_en` is 0 evaluates to 0. An enabled term whose codes are all 00 evaluates to 1.
- R3: The local sum is the OR of the enabled terms that are neither lent nor exported. When `cfg_chain_use`=1 it also includes `pexp_in`.
- R4: `pexp_out` is `pexp_in` ORed with every term whose `cfg_lend` bit is 1 and that is not exported. A lent term does not reach the local sum.
- R5: With `cfg_shr_en`=1 and `cfg_shr_sel` < 5, `shr_out` is the inverse of term `cfg_shr_sel`, and that term reaches neither the sum nor the chain. In every other case `shr_out`=1.
- R6: With `cfg_byp`=1, `mc_out` equals the local sum in the same cycle, whatever the register holds.
- R7: With `cfg_byp`=0, the register takes the sum at a rising clock edge when `ena`=1 and holds its value when `ena`=0.
- R8: `clr_n`=0 forces the register to 0 at once, without a clock edge, and overrides preset, reset and enable.
- R9: `pre_n`=0 while `clr_n`=1 forces the register to 1 at once and overrides reset and enable.
- R10: `rst`=1 clears the register to 0 at the next rising edge, taking priority over `ena`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| bus_in | input | N_IN | General routing inputs to the AND plane |
| shr_in | input | N_SHR | Shared expander pool inputs to the AND plane |
| pexp_in | input | 1 | Parallel-expander chain from the previous cell |
| cfg_mask | input | 5*2*(N_IN+N_SHR) | Per-term, per-input literal codes |
| cfg_pt_en | input | 5 | Term enables |
| cfg_lend | input | 5 | Per-term routing: 1 sends the term to the chain |
| cfg_chain_use | input | 1 | Add incoming chain to the local sum |
| cfg_shr_en | input | 1 | Enable the shared-pool export |
| cfg_shr_sel | input | 3 | Index of the exported term |
| cfg_byp | input | 1 | 1 bypasses the output register |
| ena | input | 1 | Register clock enable |
| clr_n | input | 1 | Asynchronous clear, active low |
| pre_n | input | 1 | Asynchronous preset, active low |
| mc_out | output | 1 | Cell output |
| pexp_out | output | 1 | Parallel-expander chain to the next cell |
| shr_out | output | 1 | Inverted term offered to the shared pool |

## Verification
The assertions check the following on every clock edge:
- a disabled term stays low, and an enabled blank term stays high;
- the chain input always propagates, and a consumed chain input forces the sum;
- an idle export reads 1;
- the register obeys clear, preset, reset, load and hold.

Only the bench's scenarios can show that the literal codes land on the right input positions, and that the exported term drops out of both the sum and the chain. The same holds for the asynchronous effect of clear and preset between edges, and for bypass overriding a cleared register. Agreement with an independent sum-of-products model over random configurations, both bypassed and registered, is likewise shown only by the bench.

// File: rtl/mc_pkg.sv
package mc_pkg;
  // Two-bit literal selection code per AND-plane input.
  typedef enum logic [1:0] {
    SEL_IGNORE = 2'b00,
    SEL_TRUE   = 2'b01,
    SEL_COMP   = 2'b10,
    SEL_KILL   = 2'b11
  } lit_sel_e;

  localparam int LIT_CODE_W = 2;
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm
  import mc_pkg::*;
#(
  parameter int N_AND = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_AND-1:0]            lits,
  input  logic [LIT_CODE_W*N_AND-1:0] code,
  input  logic                        en,
  output logic                        term
);
  logic [N_AND-1:0] lit_ok;

  for (genvar i = 0; i < N_AND; i++) begin : g_lit
    logic [LIT_CODE_W-1:0] c;
    assign c = code[LIT_CODE_W*i +: LIT_CODE_W];
    assign lit_ok[i] = (c == SEL_IGNORE)
                     | ((c == SEL_TRUE) &  lits[i])
                     | ((c == SEL_COMP) & ~lits[i]);
  end

  assign term = en & (&lit_ok);

  // R2: a disabled term never contributes.
  p_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |-> !term);
  // R2: an enabled term with every input ignored is a constant 1.
  p_blank_one_r2: assert property (@(posedge clk) disable iff (rst)
    (en && (code == '0)) |-> term);
endmodule

// File: rtl/mc_route.sv
module mc_route #(
  parameter int N_PT  = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PT-1:0]  pt,
  input  logic [N_PT-1:0]  lend,
  input  logic             shr_en,
  input  logic [SEL_W-1:0] shr_sel,
  input  logic             pexp_in,
  input  logic             use_chain,
  output logic             sum,
  output logic             pexp_out,
  output logic             shr_out
);
  logic [N_PT-1:0] exp_m;
  logic [N_PT-1:0] local_t;
  logic [N_PT-1:0] lent_t;

  for (genvar t = 0; t < N_PT; t++) begin : g_sel
    assign exp_m[t] = shr_en && (shr_sel == SEL_W'(t));
  end

  assign local_t  = pt & ~lend & ~exp_m;
  assign lent_t   = pt &  lend & ~exp_m;
  assign sum      = (|local_t) | (use_chain & pexp_in);
  assign pexp_out = (|lent_t) | pexp_in;
  // An out-of-range or disabled selection leaves the AND-neutral value 1.
  assign shr_out  = ~|(pt & exp_m);

  // R4: the incoming chain always travels onward.
  p_chain_pass_r4: assert property (@(posedge clk) disable iff (rst)
    pexp_in |-> pexp_out);
  // R3: a consumed chain input forces the local sum high.
  p_use_chain_r3: assert property (@(posedge clk) disable iff (rst)
    (use_chain && pexp_in) |-> sum);
  // R5: an idle export offers a 1 to the pool.
  p_shr_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !shr_en |-> shr_out);
endmodule

// File: rtl/mc_outreg.sv
module mc_outreg (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  input  logic pre_n,
  input  logic ena,
  input  logic byp,
  input  logic d,
  output logic q_out
);
  logic q;

  always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n)      q <= 1'b0;
    else if (!pre_n) q <= 1'b1;
    else if (rst)    q <= 1'b0;
    else if (ena)    q <= d;
  end

  assign q_out = byp ? d : q;

  // R8: clear holds the register at 0.
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (q == 1'b0));
  // R9: preset without clear holds the register at 1.
  p_pre_one_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !pre_n) |-> (q == 1'b1));
  // R10: reset empties the register at the following edge.
  p_rst_clear_r10: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    rst |=> (q == 1'b0));
  // R7: enabled load.
  p_load_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && pre_n && ena) |=> (!clr_n || !pre_n || q == $past(d)));
  // R7: hold while enable is low.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_n && pre_n && !ena) |=> (!clr_n || !pre_n || q == $past(q)));
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
  import mc_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int N_SHR = 16,
  parameter int N_PT  = 5,
  localparam int N_AND  = N_IN + N_SHR,
  localparam int CODE_W = LIT_CODE_W * N_AND,
  localparam int MASK_W = N_PT * CODE_W,
  localparam int SEL_W  = (N_PT > 1) ? $clog2(N_PT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   bus_in,
  input  logic [N_SHR-1:0]  shr_in,
  input  logic              pexp_in,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic [N_PT-1:0]   cfg_pt_en,
  input  logic [N_PT-1:0]   cfg_lend,
  input  logic              cfg_chain_use,
  input  logic              cfg_shr_en,
  input  logic [SEL_W-1:0]  cfg_shr_sel,
  input  logic              cfg_byp,
  input  logic              ena,
  input  logic              clr_n,
  input  logic              pre_n,
  output logic              mc_out,
  output logic              pexp_out,
  output logic              shr_out
);
  logic [N_AND-1:0] lits;
  logic [N_PT-1:0]  pt;
  logic             sum;

  assign lits = {shr_in, bus_in};

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    mc_pterm #(.N_AND(N_AND)) u_pt (
      .clk  (clk),
      .rst  (rst),
      .lits (lits),
      .code (cfg_mask[t*CODE_W +: CODE_W]),
      .en   (cfg_pt_en[t]),
      .term (pt[t])
    );
  end

  mc_route #(.N_PT(N_PT), .SEL_W(SEL_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .pt        (pt),
    .lend      (cfg_lend),
    .shr_en    (cfg_shr_en),
    .shr_sel   (cfg_shr_sel),
    .pexp_in   (pexp_in),
    .use_chain (cfg_chain_use),
    .sum       (sum),
    .pexp_out  (pexp_out),
    .shr_out   (shr_out)
  );

  mc_outreg u_reg (
    .clk   (clk),
    .rst   (rst),
    .clr_n (clr_n),
    .pre_n (pre_n),
    .ena   (ena),
    .byp   (cfg_byp),
    .d     (sum),
    .q_out (mc_out)
  );
endmodule

// File: tb/tb_sop_macrocell.sv
module tb_sop_macrocell;
  localparam int TI = 4, TS = 4, TP = 5, TA = TI + TS, CW = 2*TA, MW = TP*CW;

  typedef struct packed {
    logic [MW-1:0] mask; logic [TP-1:0] en; logic [TP-1:0] lend;
    logic shr_en; logic [2:0] sel; logic use_c; logic pin;
    logic [TI-1:0] bus; logic [TS-1:0] shr;
    logic e_sum; logic e_pexp; logic e_shr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{80'h0, 5'b00000, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{80'h0, 5'b00001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1},
    '{{64'h0,16'h0001}, 5'b00001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 1'b1, 1'b0, 1'b1},
    '{{64'h0,16'h0001}, 5'b00001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{{48'h0,16'h0002,16'h0}, 5'b00010, 5'b00010, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1},
    '{80'h0, 5'b00000, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b1},
    '{80'h0, 5'b00000, 5'b00000, 1'b0, 3'd0, 1'b1, 1'b1, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b1},
    '{{64'h0,16'h0003}, 5'b00001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{{32'h0,16'h0404,32'h0}, 5'b00100, 5'b00000, 1'b1, 3'd2, 1'b0, 1'b0, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0},
    '{{32'h0,16'h0404,32'h0}, 5'b00100, 5'b00000, 1'b1, 3'd2, 1'b0, 1'b0, 4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{{32'h0,16'h0404,32'h0}, 5'b00100, 5'b00100, 1'b1, 3'd2, 1'b0, 1'b0, 4'b0010, 4'b0010, 1'b0, 1'b0, 1'b0},
    '{80'h0, 5'b00001, 5'b00000, 1'b1, 3'd5, 1'b0, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1},
    '{{16'h0,16'h1000,32'h0,16'h0090}, 5'b01001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0100, 4'b0000, 1'b1, 1'b0, 1'b1},
    '{{16'h0,16'h1000,32'h0,16'h0090}, 5'b01001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b1100, 4'b0100, 1'b1, 1'b0, 1'b1},
    '{{16'h0,16'h1000,32'h0,16'h0090}, 5'b01001, 5'b00000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b1100, 4'b0000, 1'b0, 1'b0, 1'b1},
    '{{16'h0,16'h1000,32'h0,16'h0090}, 5'b01001, 5'b01000, 1'b0, 3'd0, 1'b0, 1'b0, 4'b1100, 4'b0100, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [TI-1:0] bus_in = '0;
  logic [TS-1:0] shr_in = '0;
  logic pexp_in = 1'b0;
  logic [MW-1:0] cfg_mask = '0;
  logic [TP-1:0] cfg_pt_en = '0, cfg_lend = '0;
  logic cfg_chain_use = 1'b0, cfg_shr_en = 1'b0, cfg_byp = 1'b0;
  logic [2:0] cfg_shr_sel = '0;
  logic ena = 1'b1, clr_n = 1'b1, pre_n = 1'b1;
  logic mc_out, pexp_out, shr_out;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sop_macrocell #(.N_IN(TI), .N_SHR(TS), .N_PT(TP)) dut (
    .clk(clk), .rst(rst), .bus_in(bus_in), .shr_in(shr_in), .pexp_in(pexp_in),
    .cfg_mask(cfg_mask), .cfg_pt_en(cfg_pt_en), .cfg_lend(cfg_lend),
    .cfg_chain_use(cfg_chain_use), .cfg_shr_en(cfg_shr_en), .cfg_shr_sel(cfg_shr_sel),
    .cfg_byp(cfg_byp), .ena(ena), .clr_n(clr_n), .pre_n(pre_n),
    .mc_out(mc_out), .pexp_out(pexp_out), .shr_out(shr_out));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    cfg_mask = v.mask; cfg_pt_en = v.en; cfg_lend = v.lend;
    cfg_shr_en = v.shr_en; cfg_shr_sel = v.sel; cfg_chain_use = v.use_c;
    pexp_in = v.pin; bus_in = v.bus; shr_in = v.shr;
  endtask

  // Independent model built from R1..R5: returns {sum, pexp_out, shr_out}.
  function automatic logic [2:0] ref_model(input vec_t v);
    logic [TA-1:0] l;
    logic [TP-1:0] p;
    logic s, c, x;
    l = {v.shr, v.bus};
    s = v.use_c & v.pin; c = v.pin; x = 1'b1;
    for (int t = 0; t < TP; t++) begin
      logic on;
      on = v.en[t];
      for (int i = 0; i < TA; i++) begin
        logic [1:0] cd;
        cd = v.mask[t*CW + 2*i +: 2];
        if (cd == 2'b11 || (cd == 2'b01 && !l[i]) || (cd == 2'b10 && l[i])) on = 1'b0;
      end
      p[t] = on;
      if (v.shr_en && v.sel == 3'(t)) x = ~on;
      else if (v.lend[t]) c = c | on;
      else s = s | on;
    end
    return {s, c, x};
  endfunction

  initial begin
    #(4*150000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t blank_one, all_off;
    blank_one = TBL[1]; all_off = TBL[0];
    // Reset state and reset priority over enable (R10).
    apply(blank_one); cfg_byp = 1'b0; ena = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R10 reset holds 0 with ena", mc_out, 1'b0);
    rst = 1'b0;
    @(posedge clk); #1 chk("R7 load after reset", mc_out, 1'b1);

    // Vector table: bypassed outputs, then registered.
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      apply(TBL[k]); cfg_byp = 1'b1; ena = 1'b1;
      #1;
      chk("R1/R2/R3/R6 table sum", mc_out, TBL[k].e_sum);
      chk("R4 table chain", pexp_out, TBL[k].e_pexp);
      chk("R5 table export", shr_out, TBL[k].e_shr);
      @(negedge clk); cfg_byp = 1'b0;
      @(posedge clk); #1 chk("R7 table registered", mc_out, TBL[k].e_sum);
    end

    // Hold and load (R7).
    @(negedge clk); apply(blank_one); @(posedge clk);
    @(negedge clk); ena = 1'b0; apply(all_off);
    @(posedge clk); #1 chk("R7 hold when ena low", mc_out, 1'b1);
    @(negedge clk); ena = 1'b1;
    @(posedge clk); #1 chk("R7 load when ena high", mc_out, 1'b0);

    // Asynchronous preset (R9).
    @(negedge clk); ena = 1'b0; pre_n = 1'b0;
    #1 chk("R9 preset without clock", mc_out, 1'b1);
    @(posedge clk); #1 chk("R9 preset held", mc_out, 1'b1);
    // Clear over preset (R8).
    @(negedge clk); clr_n = 1'b0;
    #1 chk("R8 clear beats preset", mc_out, 1'b0);
    @(negedge clk); pre_n = 1'b1;
    @(negedge clk); clr_n = 1'b1;
    @(posedge clk); #1 chk("R8 stays cleared after release", mc_out, 1'b0);
    // Preset beats synchronous reset (R9).
    @(negedge clk); pre_n = 1'b0; rst = 1'b1;
    @(posedge clk); #1 chk("R9 preset beats reset", mc_out, 1'b1);
    @(negedge clk); pre_n = 1'b1;
    @(posedge clk); #1 chk("R10 reset after preset", mc_out, 1'b0);
    @(negedge clk); rst = 1'b0;
    // Clear beats enable, bypass ignores register (R8, R6).
    @(negedge clk); apply(blank_one); ena = 1'b1; clr_n = 1'b0;
    @(posedge clk); #1 chk("R8 clear beats ena", mc_out, 1'b0);
    @(negedge clk); cfg_byp = 1'b1;
    #1 chk("R6 bypass during clear", mc_out, 1'b1);
    @(negedge clk); cfg_byp = 1'b0; clr_n = 1'b1;

    // Random configurations against the model.
    for (int k = 0; k < 300; k++) begin
      vec_t v;
      logic [2:0] e;
      v = '0;
      for (int b = 0; b < MW/2; b++) begin
        int r;
        r = int'($urandom % 8);
        v.mask[2*b +: 2] = (r < 5) ? 2'b00 : 2'(r - 4);
      end
      v.en = 5'($urandom); v.lend = 5'($urandom);
      v.shr_en = 1'($urandom); v.sel = 3'($urandom);
      v.use_c = 1'($urandom); v.pin = 1'($urandom);
      v.bus = 4'($urandom); v.shr = 4'($urandom);
      e = ref_model(v);
      @(negedge clk); apply(v); cfg_byp = 1'b1; #1;
      chk("R3 random sum", mc_out, e[2]);
      chk("R4 random chain", pexp_out, e[1]);
      chk("R5 random export", shr_out, e[0]);
      @(negedge clk); cfg_byp = 1'b0;
      @(posedge clk); #1 chk("R7 random registered", mc_out, e[2]);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule